// File: doc/BRIEF.md
# One-Wire Bus Master

This block is a bit-level master for a single-wire, open-drain serial bus. Software writes a byte-wide register bus to start one operation at a time: a bus reset with presence detection, a slot that writes a zero, or a slot that writes a one and reads the line back. While an operation runs, its command bit in the control register reads 1. The bit clears by itself when the operation ends. The presence result and the sampled data bit are then available in the same register.

All timing counts in ticks of about 1 µs. A prescaler makes these ticks by dividing the system clock by a programmable value N, and software stores N-1 in a divider register. The block only ever pulls the line low or releases it. It never drives the line high, so an external pull-up gives the idle level. The sensed line passes through a two-flop synchronizer before the block uses it.

Top module: `onewire_master`

## Requirements
- R1: After reset:
  - the control register reads 0x00;
  - the divider register reads the parameter DIV_INIT (default 99);
  - the bus-drive-low output is 0.
- R2: The control register is at offset 0x0 and the divider register is at offset 0x2. The divider can be written and read back. Offsets 0x4, 0x6, 0x8, 0xA and 0xC read 0x00.
- R3: A time tick occurs every (divider+1) system clocks. Tick counting restarts at the clock edge that accepts a command.
- R4: Writing control bit 7 = 1 starts a bus reset. The line is pulled low for 480 ticks. Bit 7 reads 1 until tick 960 and then reads 0.
- R5: Control bit 6 holds the presence result. At tick 550 of each bus reset (70 ticks after release) it is set to 1 if the line reads low and to 0 if the line reads high. It keeps that value until the next reset.
- R6: Writing control bit 5 = 1 starts a write-zero slot. The line is pulled low for 60 ticks. Bit 5 reads 1 until tick 70.
- R7: Writing control bit 4 = 1 starts a write-one/read slot. The line is pulled low for 6 ticks. Bit 4 reads 1 until tick 70.
- R8: Control bit 3 holds the line level sampled at tick 15 of the most recent write-one/read slot. No other operation changes it.
- R9: A control write made while any operation is busy is ignored. The running operation keeps its command bit and its end time.
- R10: If one write sets several command bits, only one operation starts. The bus reset goes first, then the write-zero slot, then the write-one/read slot.
- R11: The drive-low output is 0 whenever no operation is busy. The block never drives the line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| busLow | output | 1 | 1 pulls the bus line low; 0 releases it |
| busSense | input | 1 | Sensed bus line level |

## Verification
The assertions check these properties on every cycle:
- a busy operation is never replaced before its end tick;
- the tick counter stays in range;
- ticks never come back to back when the divider is not zero;
- the presence and sample bits hold between their capture points;
- the line is released whenever the block is idle and just before each operation ends.

Only the bench scenarios can show the following:
- the exact cycle each operation finishes in, for two divider settings;
- the length of the low pulse;
- the presence and data values that a simulated device produces;
- the command priority, and that a command written while busy has no effect.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_RESET,
    OP_WR0,
    OP_RDSLOT
  } opState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic restart;  // clear prescaler and tick count
    logic run;      // tick counter advances on ticks
    logic capPres;  // latch presence result
    logic capBit;   // latch read sample
  } dpStrobe_t;

  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned DIV_OFS  = 2;

endpackage

// File: rtl/onewire_dp.sv
module onewire_dp
  import onewire_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned DIV_INIT = 99,
  parameter int unsigned CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrDiv,
  input  logic [DIV_W-1:0] divIn,
  input  dpStrobe_t        strobe,
  input  logic             busSense,
  output logic [DIV_W-1:0] divQ,
  output logic             tick,
  output logic [CNT_W-1:0] tickCnt,
  output logic             presQ,
  output logic             sampleQ
);

  logic [DIV_W-1:0] preCnt;
  logic             sync1, sync2;

  assign tick = (preCnt == divQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= DIV_W'(DIV_INIT);
    end else if (wrDiv) begin
      divQ <= divIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.restart) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      if (strobe.run) tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // two-flop synchronizer, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= busSense;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presQ   <= 1'b0;
      sampleQ <= 1'b0;
    end else begin
      if (strobe.capPres) presQ <= ~sync2;
      if (strobe.capBit) sampleQ <= sync2;
    end
  end

  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divQ != '0 && !strobe.restart && !wrDiv) |=> !tick);
  a_r8_sample_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capBit |=> $stable(sampleQ));
  a_r5_pres_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capPres |=> $stable(presQ));

endmodule

// File: rtl/onewire_seq.sv
module onewire_seq
  import onewire_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned RST_LOW   = 480,
  parameter int unsigned RST_SMP   = 70,
  parameter int unsigned RST_RECOV = 480,
  parameter int unsigned W0_LOW    = 60,
  parameter int unsigned W0_RECOV  = 10,
  parameter int unsigned RD_LOW    = 6,
  parameter int unsigned RD_SMP    = 15,
  parameter int unsigned RD_END    = 70
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic             cmdReset,
  input  logic             cmdWr0,
  input  logic             cmdRead,
  input  logic             tick,
  input  logic [CNT_W-1:0] tickCnt,
  output logic             busyRst,
  output logic             busyWr0,
  output logic             busyRd,
  output logic             drive,
  output dpStrobe_t        strobe
);

  localparam logic [CNT_W-1:0] RstLowC  = CNT_W'(RST_LOW);
  localparam logic [CNT_W-1:0] RstSmpC  = CNT_W'(RST_LOW + RST_SMP - 1);
  localparam logic [CNT_W-1:0] RstLastC = CNT_W'(RST_LOW + RST_RECOV - 1);
  localparam logic [CNT_W-1:0] RstMaxC  = CNT_W'(RST_LOW + RST_RECOV);
  localparam logic [CNT_W-1:0] W0LowC   = CNT_W'(W0_LOW);
  localparam logic [CNT_W-1:0] W0LastC  = CNT_W'(W0_LOW + W0_RECOV - 1);
  localparam logic [CNT_W-1:0] RdLowC   = CNT_W'(RD_LOW);
  localparam logic [CNT_W-1:0] RdSmpC   = CNT_W'(RD_SMP - 1);
  localparam logic [CNT_W-1:0] RdLastC  = CNT_W'(RD_END - 1);

  opState_t         stateQ, stateD;
  logic [CNT_W-1:0] lowLen, lastCnt;
  logic             endNow, busyAny, startOp;

  always_comb begin
    lowLen  = '0;
    lastCnt = '0;
    unique case (stateQ)
      OP_RESET:  begin lowLen = RstLowC; lastCnt = RstLastC; end
      OP_WR0:    begin lowLen = W0LowC;  lastCnt = W0LastC;  end
      OP_RDSLOT: begin lowLen = RdLowC;  lastCnt = RdLastC;  end
      default:   ;
    endcase
  end

  assign busyAny = (stateQ != OP_IDLE);
  assign endNow  = busyAny && tick && (tickCnt == lastCnt);
  assign startOp = !busyAny && cmdWr && (cmdReset || cmdWr0 || cmdRead);

  always_comb begin
    stateD = stateQ;
    if (!busyAny && cmdWr) begin
      if (cmdReset)     stateD = OP_RESET;   // highest priority
      else if (cmdWr0)  stateD = OP_WR0;
      else if (cmdRead) stateD = OP_RDSLOT;
    end else if (endNow) begin
      stateD = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= OP_IDLE;
    else       stateQ <= stateD;
  end

  assign busyRst = (stateQ == OP_RESET);
  assign busyWr0 = (stateQ == OP_WR0);
  assign busyRd  = (stateQ == OP_RDSLOT);
  assign drive   = busyAny && (tickCnt < lowLen);

  always_comb begin
    strobe.restart = startOp;
    strobe.run     = busyAny;
    strobe.capPres = busyRst && tick && (tickCnt == RstSmpC);
    strobe.capBit  = busyRd && tick && (tickCnt == RdSmpC);
  end

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busyAny && !endNow) |=> (stateQ == $past(stateQ)));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= RstMaxC);
  a_r11_release_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyAny) |-> !$past(drive));

endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import onewire_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_INIT  = 99,
  parameter int unsigned RST_LOW   = 480,
  parameter int unsigned RST_SMP   = 70,
  parameter int unsigned RST_RECOV = 480,
  parameter int unsigned W0_LOW    = 60,
  parameter int unsigned W0_RECOV  = 10,
  parameter int unsigned RD_LOW    = 6,
  parameter int unsigned RD_SMP    = 15,
  parameter int unsigned RD_END    = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              busLow,
  input  logic              busSense
);

  localparam int unsigned CNT_W = $clog2(RST_LOW + RST_RECOV + 1);

  dpStrobe_t        strobe;
  logic             wrCtrl, wrDiv, tick, presQ, sampleQ;
  logic             busyRst, busyWr0, busyRd;
  logic [DIV_W-1:0] divQ;
  logic [CNT_W-1:0] tickCnt;

  assign wrCtrl = regWe && (regAddr == ADDR_W'(CTRL_OFS));
  assign wrDiv  = regWe && (regAddr == ADDR_W'(DIV_OFS));

  onewire_seq #(
    .CNT_W(CNT_W), .RST_LOW(RST_LOW), .RST_SMP(RST_SMP), .RST_RECOV(RST_RECOV),
    .W0_LOW(W0_LOW), .W0_RECOV(W0_RECOV), .RD_LOW(RD_LOW), .RD_SMP(RD_SMP),
    .RD_END(RD_END)
  ) u_seq (
    .clk(clk), .rstN(rstN), .cmdWr(wrCtrl),
    .cmdReset(regWdata[7]), .cmdWr0(regWdata[5]), .cmdRead(regWdata[4]),
    .tick(tick), .tickCnt(tickCnt),
    .busyRst(busyRst), .busyWr0(busyWr0), .busyRd(busyRd),
    .drive(busLow), .strobe(strobe)
  );

  onewire_dp #(
    .DIV_W(DIV_W), .DIV_INIT(DIV_INIT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrDiv(wrDiv), .divIn(regWdata[DIV_W-1:0]),
    .strobe(strobe), .busSense(busSense), .divQ(divQ), .tick(tick),
    .tickCnt(tickCnt), .presQ(presQ), .sampleQ(sampleQ)
  );

  always_comb begin
    regRdata = 8'h00;
    if (regAddr == ADDR_W'(CTRL_OFS))
      regRdata = {busyRst, presQ, busyWr0, busyRd, sampleQ, 3'b000};
    else if (regAddr == ADDR_W'(DIV_OFS))
      regRdata = 8'(divQ);
  end

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !(busyRst || busyWr0 || busyRd) |-> !busLow);

endmodule

// File: tb/onewire_master_tb.sv
module onewire_master_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       busLow;
  logic       devLow = 1'b0;
  logic       busSense;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign busSense = !busLow && !devLow;

  onewire_master u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .busLow(busLow),
    .busSense(busSense)
  );

  // mode: 0 no device, 1 presence pulse, 2 device holds line low in slot
  typedef struct packed {
    logic [7:0]  cmd;
    logic [1:0]  mode;
    logic [11:0] endC;
    logic [11:0] lowC;
    logic [7:0]  expCtrl;
    logic [7:0]  busyExp;
  } vec_t;

  // timings for divider = 3 (4 clocks per tick)
  localparam vec_t VT [8] = '{
    '{8'h80, 2'd1, 12'd3840, 12'd1920, 8'h40, 8'h80},  // R4 R5 present
    '{8'h80, 2'd0, 12'd3840, 12'd1920, 8'h00, 8'h80},  // R4 R5 absent
    '{8'h20, 2'd0, 12'd280,  12'd240,  8'h00, 8'h20},  // R6
    '{8'h10, 2'd0, 12'd280,  12'd24,   8'h08, 8'h10},  // R7 R8 one
    '{8'h10, 2'd2, 12'd280,  12'd24,   8'h00, 8'h10},  // R7 R8 zero
    '{8'h10, 2'd0, 12'd280,  12'd24,   8'h08, 8'h10},  // R8 one again
    '{8'hB0, 2'd0, 12'd3840, 12'd1920, 8'h08, 8'h80},  // R10 reset first
    '{8'h30, 2'd0, 12'd280,  12'd240,  8'h08, 8'h20}   // R10 write-zero next
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int lowCnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busLow", int'(busLow), 0);
    rd(4'h0, d); check("R1 ctrl", d, 8'h00);
    rd(4'h2, d); check("R1 divider", d, 99);
    rstN = 1'b1;
    @(negedge clk);
    // R2 unused offsets
    for (int a = 4; a <= 12; a += 2) begin
      rd(4'(a), d); check("R2 unused offset", d, 8'h00);
    end
    wr(4'h2, 8'h03);
    rd(4'h2, d); check("R2 divider readback", d, 8'h03);

    // vector table: R4 R5 R6 R7 R8 R10 R11
    foreach (VT[i]) begin
      wr(4'h0, VT[i].cmd);
      lowCnt = 0;
      for (int c = 0; c <= int'(VT[i].endC); c++) begin
        if (c > 0) @(negedge clk);
        if (VT[i].mode == 2'd1) devLow = (c >= 2000 && c < 2400);
        else if (VT[i].mode == 2'd2) devLow = (c < 100);
        else devLow = 1'b0;
        if (busLow) lowCnt++;
        if (c == int'(VT[i].endC) - 1) begin
          rd(4'h0, d);
          check("R4 R6 R7 R10 busy before end", d & 8'hB0, VT[i].busyExp);
        end
      end
      devLow = 1'b0;
      rd(4'h0, d);
      check("R5 R8 R10 ctrl after end", d, VT[i].expCtrl);
      check("R4 R6 R7 R11 low pulse cycles", lowCnt, VT[i].lowC);
      check("R11 released idle", int'(busLow), 0);
    end

    // R9: reset command during a read slot is ignored
    wr(4'h0, 8'h10);
    repeat (4) @(negedge clk);
    wr(4'h0, 8'h80);
    repeat (274) @(negedge clk);
    rd(4'h0, d); check("R9 still read slot", d, 8'h18);
    @(negedge clk);
    rd(4'h0, d); check("R9 ends on schedule", d, 8'h08);

    // R3: divider 1 gives two clocks per tick, write-zero ends at 140
    wr(4'h2, 8'h01);
    wr(4'h0, 8'h20);
    repeat (139) @(negedge clk);
    rd(4'h0, d); check("R3 busy at 139", d, 8'h28);
    @(negedge clk);
    rd(4'h0, d); check("R3 done at 140", d, 8'h08);
    wr(4'h2, 8'h03);

    finish_run();
  end

endmodule